// File: doc/BRIEF.md
# Dual Data Buffer with Auto-Increment Port

This block is the word store that sits between a card controller's host register interface and its card-side transfer engine. It holds two buffers of 64 words each, with 64 bits in a word, so each buffer carries 512 bytes. Software reaches the storage through two host registers. A pointer register chooses a buffer and a word offset, and can turn on auto-increment. A data register then moves 64-bit words in or out at the pointed location. The card-side engine reaches the same storage through its own word port, which takes a buffer select and a word address.

Byte streams are packed most-significant first: the first byte of a transfer occupies bits 63:56 of a word, and each later byte sits eight bits lower. A transfer of N words, with N below 64, is placed so that it ends at word 63. Software sets the starting offset to 64 − N and streams the words with auto-increment on. Host fills of the transmit buffer use buffer 0 from offset 0.

Only one side reaches the storage in a cycle, and the card port always has priority. The host side runs a two-state machine. In IDLE the host port may be accepted. An accepted read of either register moves it to RESP. In RESP the read word is presented and the host port is not ready, and the machine returns to IDLE on the next edge. IDLE→RESP is taken on an accepted host read. RESP→IDLE is taken unconditionally. All host writes stay in IDLE.

Top module: `dbuf_core`

## Requirements
- R1: After reset the pointer register reads as zero: buffer 0, offset 0, auto-increment off. host_rvalid is low and host_ready is high.
- R2: A write to the pointer register (host_sel_data=0) loads the offset from bits 5:0, the buffer select from bit 6 and auto-increment from bit 16. A pointer read returns those fields at the same positions and zero in every other bit.
- R3: A host data write (host_sel_data=1) stores host_wdata at the pointed buffer and offset. The stored word can be read from the card port.
- R4: An accepted host read raises host_rvalid in the next cycle only, and presents the read word on host_rdata in that cycle.
- R5: With auto-increment on, each data access advances the offset by one. With it off, the offset stays unchanged.
- R6: With auto-increment on, the offset wraps from 63 to 0 and the buffer select is unchanged. A run of N words started at offset 64 − N therefore ends at word 63.
- R7: During the response cycle of a read, host_ready is low. The offset advances at the end of that cycle, so consecutive data reads return consecutive words.
- R8: While card_req is high, host_ready is low and a host request in that cycle has no effect. The card access completes in that cycle.
- R9: A card read returns the addressed word on card_rdata in the cycle after card_req. Card writes are visible to host data reads.
- R10: The two buffers are independent: the same offset in buffer 0 and in buffer 1 holds different words.
- R11: Word bits pass through unchanged in both directions, so the first byte of a stream, placed at bits 63:56, is read back at bits 63:56.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_req | input | 1 | Host register access request |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_sel_data | input | 1 | 1 = data register, 0 = pointer register |
| host_wdata | input | 64 | Host write data |
| host_ready | output | 1 | Host request accepted at this edge when high |
| host_rvalid | output | 1 | host_rdata holds the read result |
| host_rdata | output | 64 | Host read data |
| card_req | input | 1 | Card port access request (has priority) |
| card_wr | input | 1 | 1 = card write, 0 = card read |
| card_bsel | input | 1 | Card port buffer select |
| card_word | input | 6 | Card port word address |
| card_wdata | input | 64 | Card write data |
| card_rdata | output | 64 | Card read data, valid the cycle after a card read |

## Verification
Single writes with auto-increment off show whether data lands at the pointed slot while the pointer stays fixed. Bursts from offset 0 and short runs starting at offset 60 tell linear advance apart from the wrap back to 0. They also show whether the wrap stays inside the selected buffer. Back-to-back data reads show whether the offset moves only after each response, and not at acceptance. Colliding host and card requests show whether the card takes the cycle and the stalled host write lands exactly once. Words written to the same offset in both buffers, and a byte-ordered word, confirm that the buffers are separate and that bit placement is kept.

// File: rtl/dbuf_pkg.sv
package dbuf_pkg;
    localparam int DBUF_WORDS    = 64;
    localparam int DBUF_NBUF     = 2;
    localparam int DBUF_DW       = 64;
    localparam int DBUF_AINC_BIT = 16;
    localparam int DBUF_BUF_LSB  = 6;

    typedef enum logic [0:0] {
        H_IDLE = 1'b0,
        H_RESP = 1'b1
    } host_state_e;
endpackage

// File: rtl/dbuf_index.sv
module dbuf_index #(
    parameter int WORDS    = dbuf_pkg::DBUF_WORDS,
    parameter int NBUF     = dbuf_pkg::DBUF_NBUF,
    parameter int DW       = dbuf_pkg::DBUF_DW,
    parameter int AINC_BIT = dbuf_pkg::DBUF_AINC_BIT,
    parameter int BUF_LSB  = dbuf_pkg::DBUF_BUF_LSB,
    localparam int OFF_W   = $clog2(WORDS),
    localparam int BUF_W   = (NBUF > 1) ? $clog2(NBUF) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld,
    input  logic [DW-1:0]    ld_word,
    input  logic             adv,
    output logic [OFF_W-1:0] off_o,
    output logic [BUF_W-1:0] bsel_o,
    output logic             ainc_o,
    output logic [DW-1:0]    word_o
);
    localparam logic [OFF_W-1:0] OFF_LAST = OFF_W'(WORDS - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off_o  <= '0;
            bsel_o <= '0;
            ainc_o <= 1'b0;
        end else if (ld) begin
            off_o  <= ld_word[OFF_W-1:0];
            bsel_o <= ld_word[BUF_LSB +: BUF_W];
            ainc_o <= ld_word[AINC_BIT];
        end else if (adv && ainc_o) begin
            off_o  <= (off_o == OFF_LAST) ? '0 : off_o + 1'b1;
        end
    end

    always_comb begin
        word_o                    = '0;
        word_o[OFF_W-1:0]         = off_o;
        word_o[BUF_LSB +: BUF_W]  = bsel_o;
        word_o[AINC_BIT]          = ainc_o;
    end
endmodule

// File: rtl/dbuf_store.sv
module dbuf_store #(
    parameter int DEPTH = dbuf_pkg::DBUF_WORDS * dbuf_pkg::DBUF_NBUF,
    parameter int DW    = dbuf_pkg::DBUF_DW,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          en,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (en) begin
            if (we) mem[addr] <= wdata;
            else    rdata     <= mem[addr];
        end
    end
endmodule

// File: rtl/dbuf_host_fsm.sv
module dbuf_host_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic host_req,
    input  logic host_wr,
    input  logic host_sel_data,
    input  logic card_req,
    output logic host_ready,
    output logic host_rvalid,
    output logic idx_ld,
    output logic data_wr,
    output logic data_rd,
    output logic rd_accept,
    output logic adv,
    output logic resp_data
);
    import dbuf_pkg::*;

    host_state_e state, state_nx;
    logic        accept;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= H_IDLE;
            resp_data <= 1'b0;
        end else begin
            state <= state_nx;
            if (rd_accept) resp_data <= host_sel_data;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            H_IDLE: if (rd_accept) state_nx = H_RESP;
            H_RESP: state_nx = H_IDLE;
            default: state_nx = H_IDLE;
        endcase
    end

    always_comb begin
        host_ready  = (state == H_IDLE) && !card_req;
        accept      = host_req && host_ready;
        idx_ld      = accept && host_wr && !host_sel_data;
        data_wr     = accept && host_wr && host_sel_data;
        data_rd     = accept && !host_wr && host_sel_data;
        rd_accept   = accept && !host_wr;
        host_rvalid = (state == H_RESP);
        adv         = data_wr || ((state == H_RESP) && resp_data);
    end
endmodule

// File: rtl/dbuf_core.sv
module dbuf_core #(
    parameter int WORDS    = dbuf_pkg::DBUF_WORDS,
    parameter int NBUF     = dbuf_pkg::DBUF_NBUF,
    parameter int DW       = dbuf_pkg::DBUF_DW,
    parameter int AINC_BIT = dbuf_pkg::DBUF_AINC_BIT,
    parameter int BUF_LSB  = dbuf_pkg::DBUF_BUF_LSB,
    localparam int OFF_W   = $clog2(WORDS),
    localparam int BUF_W   = (NBUF > 1) ? $clog2(NBUF) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_req,
    input  logic             host_wr,
    input  logic             host_sel_data,
    input  logic [DW-1:0]    host_wdata,
    output logic             host_ready,
    output logic             host_rvalid,
    output logic [DW-1:0]    host_rdata,
    input  logic             card_req,
    input  logic             card_wr,
    input  logic [BUF_W-1:0] card_bsel,
    input  logic [OFF_W-1:0] card_word,
    input  logic [DW-1:0]    card_wdata,
    output logic [DW-1:0]    card_rdata
);
    localparam int DEPTH = WORDS * NBUF;
    localparam int AW    = $clog2(DEPTH);

    logic             idx_ld, data_wr, data_rd, rd_accept, adv, resp_data;
    logic [OFF_W-1:0] idx_off;
    logic [BUF_W-1:0] idx_bsel;
    logic             idx_ainc;
    logic [DW-1:0]    idx_word, idx_snap;
    logic             st_en, st_we;
    logic [AW-1:0]    st_addr;
    logic [DW-1:0]    st_wdata, st_rdata;

    dbuf_host_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .host_req(host_req), .host_wr(host_wr), .host_sel_data(host_sel_data),
        .card_req(card_req),
        .host_ready(host_ready), .host_rvalid(host_rvalid),
        .idx_ld(idx_ld), .data_wr(data_wr), .data_rd(data_rd),
        .rd_accept(rd_accept), .adv(adv), .resp_data(resp_data)
    );

    dbuf_index #(
        .WORDS(WORDS), .NBUF(NBUF), .DW(DW),
        .AINC_BIT(AINC_BIT), .BUF_LSB(BUF_LSB)
    ) u_index (
        .clk(clk), .rst_n(rst_n),
        .ld(idx_ld), .ld_word(host_wdata), .adv(adv),
        .off_o(idx_off), .bsel_o(idx_bsel), .ainc_o(idx_ainc), .word_o(idx_word)
    );

    always_comb begin
        st_en = card_req || data_wr || data_rd;
        if (card_req) begin
            st_we    = card_wr;
            st_addr  = AW'(card_bsel) * AW'(WORDS) + AW'(card_word);
            st_wdata = card_wdata;
        end else begin
            st_we    = data_wr;
            st_addr  = AW'(idx_bsel) * AW'(WORDS) + AW'(idx_off);
            st_wdata = host_wdata;
        end
    end

    dbuf_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
        .clk(clk), .en(st_en), .we(st_we), .addr(st_addr),
        .wdata(st_wdata), .rdata(st_rdata)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         idx_snap <= '0;
        else if (rd_accept) idx_snap <= idx_word;
    end

    assign host_rdata = resp_data ? st_rdata : idx_snap;
    assign card_rdata = st_rdata;
endmodule

// File: rtl/dbuf_core_chk.sv
module dbuf_core_chk #(
    parameter int WORDS  = dbuf_pkg::DBUF_WORDS,
    localparam int OFF_W = $clog2(WORDS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             host_req,
    input logic             host_wr,
    input logic             host_sel_data,
    input logic             host_ready,
    input logic             host_rvalid,
    input logic             card_req,
    input logic [OFF_W-1:0] idx_off,
    input logic             idx_ainc
);
    logic acc_rd, acc_dwr;
    assign acc_rd  = host_req && host_ready && !host_wr;
    assign acc_dwr = host_req && host_ready && host_wr && host_sel_data;

    a_r8_card_wins: assert property (@(posedge clk) disable iff (!rst_n)
        card_req |-> !host_ready);

    a_r7_stall_in_resp: assert property (@(posedge clk) disable iff (!rst_n)
        host_rvalid |-> !host_ready);

    a_r4_resp_next: assert property (@(posedge clk) disable iff (!rst_n)
        acc_rd |=> host_rvalid);

    a_r4_resp_once: assert property (@(posedge clk) disable iff (!rst_n)
        host_rvalid |=> !host_rvalid);

    a_r5_hold_no_ainc: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_dwr && !idx_ainc) |=> $stable(idx_off));

    a_r6_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_dwr && idx_ainc && idx_off == OFF_W'(WORDS - 1)) |=> (idx_off == '0));
endmodule

bind dbuf_core dbuf_core_chk #(.WORDS(WORDS)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .host_req(host_req), .host_wr(host_wr), .host_sel_data(host_sel_data),
    .host_ready(host_ready), .host_rvalid(host_rvalid),
    .card_req(card_req), .idx_off(idx_off), .idx_ainc(idx_ainc)
);

// File: tb/tb_dbuf_core.sv
module tb_dbuf_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 0, host_wr = 0, host_sel_data = 0;
    logic [63:0] host_wdata = '0;
    logic        host_ready, host_rvalid;
    logic [63:0] host_rdata;
    logic        card_req = 0, card_wr = 0;
    logic [0:0]  card_bsel = '0;
    logic [5:0]  card_word = '0;
    logic [63:0] card_wdata = '0;
    logic [63:0] card_rdata;

    int errors = 0, checks = 0;
    bit done = 0;

    always #10 clk = ~clk;

    dbuf_core dut (.*);

    function automatic logic [63:0] ptr(input bit ainc, input bit bs, input int off);
        return (64'(ainc) << 16) | (64'(bs) << 6) | 64'(off[5:0]);
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic host_write(input bit sel, input logic [63:0] d);
        @(negedge clk);
        host_req = 1; host_wr = 1; host_sel_data = sel; host_wdata = d;
        #1;
        while (!host_ready) begin @(negedge clk); #1; end
        @(negedge clk);
        host_req = 0; host_wr = 0;
    endtask

    task automatic host_read(input bit sel, output logic [63:0] d, output logic rdy_in_resp);
        @(negedge clk);
        host_req = 1; host_wr = 0; host_sel_data = sel;
        #1;
        while (!host_ready) begin @(negedge clk); #1; end
        @(negedge clk);
        host_req = 0;
        chk("R4 rvalid", 64'(host_rvalid), 64'd1);
        d = host_rdata;
        rdy_in_resp = host_ready;
    endtask

    task automatic card_write(input bit bs, input int w, input logic [63:0] d);
        @(negedge clk);
        card_req = 1; card_wr = 1; card_bsel = bs; card_word = w[5:0]; card_wdata = d;
        @(negedge clk);
        card_req = 0; card_wr = 0;
    endtask

    task automatic card_read(input bit bs, input int w, output logic [63:0] d);
        @(negedge clk);
        card_req = 1; card_wr = 0; card_bsel = bs; card_word = w[5:0];
        @(negedge clk);
        card_req = 0;
        d = card_rdata;
    endtask

    task automatic t_reset;
        logic [63:0] d; logic r;
        chk("R1 ready", 64'(host_ready), 64'd1);
        chk("R1 rvalid", 64'(host_rvalid), 64'd0);
        host_read(0, d, r);
        chk("R1 pointer", d, 64'd0);
    endtask

    task automatic t_pointer;
        logic [63:0] d; logic r;
        host_write(0, 64'hFFFF_FFFF_FFFF_FFFF);
        host_read(0, d, r);
        chk("R2 fields", d, ptr(1, 1, 63));
    endtask

    task automatic t_single_write;
        logic [63:0] d; logic r;
        host_write(0, ptr(0, 0, 5));
        host_write(1, 64'hA5A5_0000_1234_5678);
        card_read(0, 5, d);
        chk("R3 stored", d, 64'hA5A5_0000_1234_5678);
        host_read(0, d, r);
        chk("R5 no advance", d, ptr(0, 0, 5));
    endtask

    task automatic t_host_read;
        logic [63:0] d; logic r;
        card_write(1, 9, 64'hBEEF_0009_0000_0001);
        host_write(0, ptr(0, 1, 9));
        host_read(1, d, r);
        chk("R9 card to host", d, 64'hBEEF_0009_0000_0001);
        chk("R7 not ready in resp", 64'(r), 64'd0);
    endtask

    task automatic t_burst;
        logic [63:0] d; logic r;
        host_write(0, ptr(1, 0, 0));
        for (int i = 0; i < 3; i++) host_write(1, 64'h1000 + 64'(i));
        for (int i = 0; i < 3; i++) begin
            card_read(0, i, d);
            chk("R5 burst word", d, 64'h1000 + 64'(i));
        end
        host_read(0, d, r);
        chk("R5 advanced", d, ptr(1, 0, 3));
    endtask

    task automatic t_short_wrap;
        logic [63:0] d; logic r;
        host_write(0, ptr(1, 1, 60));
        for (int i = 0; i < 4; i++) host_write(1, 64'h6000 + 64'(i));
        card_read(1, 63, d);
        chk("R6 ends at 63", d, 64'h6003);
        host_read(0, d, r);
        chk("R6 wrap to 0 same buffer", d, ptr(1, 1, 0));
        card_read(0, 0, d);
        chk("R10 buffer 0 untouched", d, 64'h1000);
    endtask

    task automatic t_read_stream;
        logic [63:0] d; logic r;
        host_write(0, ptr(1, 1, 60));
        for (int i = 0; i < 4; i++) begin
            host_read(1, d, r);
            chk("R7 consecutive read", d, 64'h6000 + 64'(i));
        end
        host_read(0, d, r);
        chk("R7 offset after reads", d, ptr(1, 1, 0));
    endtask

    task automatic t_priority;
        logic [63:0] d; logic r;
        host_write(0, ptr(1, 0, 20));
        @(negedge clk);
        card_req = 1; card_wr = 1; card_bsel = 0; card_word = 6'd30; card_wdata = 64'hCA4D;
        host_req = 1; host_wr = 1; host_sel_data = 1; host_wdata = 64'h4057;
        #1;
        chk("R8 host stalled", 64'(host_ready), 64'd0);
        @(negedge clk);
        card_req = 0; card_wr = 0;
        #1;
        chk("R8 ready after card", 64'(host_ready), 64'd1);
        @(negedge clk);
        host_req = 0; host_wr = 0;
        card_read(0, 30, d);
        chk("R8 card write", d, 64'hCA4D);
        card_read(0, 20, d);
        chk("R8 host write landed", d, 64'h4057);
        host_read(0, d, r);
        chk("R8 single advance", d, ptr(1, 0, 21));
    endtask

    task automatic t_bytes_and_buffers;
        logic [63:0] d; logic r;
        host_write(0, ptr(0, 0, 40));
        host_write(1, 64'h0102_0304_0506_0708);
        card_read(0, 40, d);
        chk("R11 first byte", 64'(d[63:56]), 64'h01);
        chk("R11 last byte", 64'(d[7:0]), 64'h08);
        host_write(0, ptr(0, 1, 40));
        host_write(1, 64'hFFFF_0000_FFFF_0000);
        card_read(0, 40, d);
        chk("R10 buffer 0 kept", d, 64'h0102_0304_0506_0708);
        host_read(1, d, r);
        chk("R10 buffer 1 word", d, 64'hFFFF_0000_FFFF_0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_pointer();
        t_single_write();
        t_host_read();
        t_burst();
        t_short_wrap();
        t_read_stream();
        t_priority();
        t_bytes_and_buffers();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule